// File: doc/BRIEF.md
# Status Flag Builder

A purely combinational unit that turns one ALU result into the next 16-bit flags word of a 16-bit processor core. It takes both operands, the result, the carry out of the operating width's top bit, the carry out of bit 3, a two-bit operation class and a byte/word select. From these it computes carry, parity, auxiliary carry, zero, sign and overflow at the selected width. These six flags are packed together with the three control flags, which it copies from the previous flags word, into a fixed layout whose unused bits hold constants.

The arithmetic itself is not part of this block. Storing the flags register is not part of it either, and neither is writing the control flags. The caller places the current flags word on `flags_prev` and registers `flags_next` wherever its pipeline needs it.

Top module: `status_flag_builder`

## Requirements
- R1: Bit positions of `flags_next`: C=0, P=2, A=4, Z=6, S=7, T=8, I=9, D=10, O=11. The unused bits 15:12, 5, 3 and 1 always read 0,0,0,0 / 0 / 0 / 1 (bit 1 is 1), whatever `flags_prev` holds.
- R2: Bits 8 (T), 9 (I) and 10 (D) of `flags_next` equal the same bits of `flags_prev`.
- R3: S equals `result[7]` when `word_op`=0 and `result[15]` when `word_op`=1.
- R4: Z is 1 exactly when `result[7:0]` is zero (`word_op`=0) or `result[15:0]` is zero (`word_op`=1). Upper result bits are ignored in byte mode.
- R5: P is 1 when `result[7:0]` holds an even number of ones, in both widths.
- R6: C equals `carry_msb` for add and subtract, and is 0 for the logic classes.
- R7: A equals `carry_nib` for add and subtract. For the logic classes it keeps bit 4 of `flags_prev`.
- R8: For add, O is 1 when both operands have the same sign at the operating width and the result's sign differs from it.
- R9: For subtract, O is 1 when the operand signs differ and the result's sign differs from the sign of `opnd_a`. For the logic classes O is 0.
- R10: `op_kind` encoding: 2'b00 add, 2'b01 subtract, 2'b10 and 2'b11 both logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | First ALU operand |
| opnd_b | input | 16 | Second ALU operand |
| result | input | 16 | ALU result |
| carry_msb | input | 1 | Carry or borrow out of the top bit at the operating width |
| carry_nib | input | 1 | Carry or borrow out of bit 3 |
| op_kind | input | 2 | Operation class (R10) |
| word_op | input | 1 | 0 = byte width, 1 = word width |
| flags_prev | input | 16 | Current flags word |
| flags_next | output | 16 | Computed flags word |

## Verification
Every output bit is a pure function of the current inputs, so each result is due in the same cycle as its stimulus, with zero register stages. The bench changes all inputs together on a falling clock edge. It reads `flags_next` one nanosecond later, well before the next rising edge, so no check ever straddles an input change. The expected words are worked out by hand from the requirements and written as literals.

// File: rtl/flag_pkg.sv
package flag_pkg;
   localparam int FLAGS_W = 16;
   localparam int POS_C = 0;
   localparam int POS_P = 2;
   localparam int POS_A = 4;
   localparam int POS_Z = 6;
   localparam int POS_S = 7;
   localparam int POS_T = 8;
   localparam int POS_I = 9;
   localparam int POS_D = 10;
   localparam int POS_O = 11;

   typedef enum logic [1:0] {
      OPK_ADD  = 2'b00,
      OPK_SUB  = 2'b01,
      OPK_LOGA = 2'b10,
      OPK_LOGB = 2'b11
   } op_kind_e;

   function automatic logic is_arith(op_kind_e k);
      return (k == OPK_ADD) || (k == OPK_SUB);
   endfunction
endpackage

// File: rtl/flag_width_view.sv
module flag_width_view #(
   parameter int DATA_W = 16,
   parameter int LOW_W  = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] r,
   input  logic              wide,
   output logic              sgn_a,
   output logic              sgn_b,
   output logic              sgn_r,
   output logic              r_zero
);
   localparam int HI_W = DATA_W - LOW_W;

   logic low_zero;
   logic high_zero;

   assign low_zero  = (r[LOW_W-1:0] == '0);
   assign high_zero = (r[DATA_W-1:LOW_W] == {HI_W{1'b0}});

   always_comb begin
      if (wide) begin
         sgn_a = a[DATA_W-1];
         sgn_b = b[DATA_W-1];
         sgn_r = r[DATA_W-1];
      end else begin
         sgn_a = a[LOW_W-1];
         sgn_b = b[LOW_W-1];
         sgn_r = r[LOW_W-1];
      end
   end

   assign r_zero = low_zero & (high_zero | ~wide);
endmodule

// File: rtl/flag_parity.sv
module flag_parity #(
   parameter int PAR_W = 8
) (
   input  logic [PAR_W-1:0] bits,
   output logic             even
);
   logic [PAR_W:0] chain;

   assign chain[0] = 1'b0;
   for (genvar k = 0; k < PAR_W; k++) begin : g_xor
      assign chain[k+1] = chain[k] ^ bits[k];
   end

   assign even = ~chain[PAR_W];
endmodule

// File: rtl/flag_arith.sv
module flag_arith
   import flag_pkg::*;
(
   input  op_kind_e kind,
   input  logic     sgn_a,
   input  logic     sgn_b,
   input  logic     sgn_r,
   input  logic     carry_msb,
   input  logic     carry_nib,
   input  logic     aux_prev,
   output logic     c_out,
   output logic     a_out,
   output logic     o_out
);
   logic same_sign;
   logic res_flip;

   assign same_sign = ~(sgn_a ^ sgn_b);
   assign res_flip  = sgn_r ^ sgn_a;

   always_comb begin
      unique case (kind)
         OPK_ADD: begin
            c_out = carry_msb;
            a_out = carry_nib;
            o_out = same_sign & res_flip;
         end
         OPK_SUB: begin
            c_out = carry_msb;
            a_out = carry_nib;
            o_out = ~same_sign & res_flip;
         end
         default: begin
            c_out = 1'b0;
            a_out = aux_prev;
            o_out = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/status_flag_builder.sv
module status_flag_builder
   import flag_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter int          LOW_W      = 8,
   parameter logic [15:0] FIXED_BITS = 16'h0002
) (
   input  logic [DATA_W-1:0]  opnd_a,
   input  logic [DATA_W-1:0]  opnd_b,
   input  logic [DATA_W-1:0]  result,
   input  logic               carry_msb,
   input  logic               carry_nib,
   input  logic [1:0]         op_kind,
   input  logic               word_op,
   input  logic [FLAGS_W-1:0] flags_prev,
   output logic [FLAGS_W-1:0] flags_next
);
   localparam logic [FLAGS_W-1:0] LIVE_MASK =
      (FLAGS_W'(1) << POS_C) | (FLAGS_W'(1) << POS_P) | (FLAGS_W'(1) << POS_A) |
      (FLAGS_W'(1) << POS_Z) | (FLAGS_W'(1) << POS_S) | (FLAGS_W'(1) << POS_T) |
      (FLAGS_W'(1) << POS_I) | (FLAGS_W'(1) << POS_D) | (FLAGS_W'(1) << POS_O);
   localparam logic [FLAGS_W-1:0] CTRL_MASK =
      (FLAGS_W'(1) << POS_T) | (FLAGS_W'(1) << POS_I) | (FLAGS_W'(1) << POS_D);

   if (DATA_W != 2 * LOW_W) begin : g_bad_width
      $error("status_flag_builder: DATA_W must be twice LOW_W");
   end
   if ((FIXED_BITS & LIVE_MASK) != '0) begin : g_bad_fixed
      $error("status_flag_builder: FIXED_BITS overlaps live flag bits");
   end

   op_kind_e kind;
   logic     sgn_a, sgn_b, sgn_r, r_zero;
   logic     par_even;
   logic     c_bit, a_bit, o_bit;

   assign kind = op_kind_e'(op_kind);

   flag_width_view #(.DATA_W(DATA_W), .LOW_W(LOW_W)) i_view (
      .a      (opnd_a),
      .b      (opnd_b),
      .r      (result),
      .wide   (word_op),
      .sgn_a  (sgn_a),
      .sgn_b  (sgn_b),
      .sgn_r  (sgn_r),
      .r_zero (r_zero)
   );

   flag_parity #(.PAR_W(LOW_W)) i_par (
      .bits (result[LOW_W-1:0]),
      .even (par_even)
   );

   flag_arith i_arith (
      .kind      (kind),
      .sgn_a     (sgn_a),
      .sgn_b     (sgn_b),
      .sgn_r     (sgn_r),
      .carry_msb (carry_msb),
      .carry_nib (carry_nib),
      .aux_prev  (flags_prev[POS_A]),
      .c_out     (c_bit),
      .a_out     (a_bit),
      .o_out     (o_bit)
   );

   always_comb begin
      flags_next        = FIXED_BITS | (flags_prev & CTRL_MASK);
      flags_next[POS_C] = c_bit;
      flags_next[POS_P] = par_even;
      flags_next[POS_A] = a_bit;
      flags_next[POS_Z] = r_zero;
      flags_next[POS_S] = sgn_r;
      flags_next[POS_O] = o_bit;
   end
endmodule

// File: rtl/status_flag_checker.sv
module status_flag_checker
   import flag_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic [DATA_W-1:0]  opnd_a,
   input logic [DATA_W-1:0]  opnd_b,
   input logic [DATA_W-1:0]  result,
   input logic               carry_msb,
   input logic               carry_nib,
   input logic [1:0]         op_kind,
   input logic               word_op,
   input logic [FLAGS_W-1:0] flags_prev,
   input logic [FLAGS_W-1:0] flags_next
);
   always_comb begin
      // R1
      rsvd_bits_chk: assert ({flags_next[15:12], flags_next[5], flags_next[3], flags_next[1]} == 7'b0000001)
         else $error("reserved bits wrong");
      // R2
      ctrl_pass_chk: assert (flags_next[10:8] == flags_prev[10:8])
         else $error("control flags not passed");
      // R5
      parity_chk: assert (flags_next[POS_P] == ($countones(result[7:0]) % 2 == 0))
         else $error("parity wrong");
      // R4
      zero_chk: assert (!flags_next[POS_Z] || result[7:0] == 8'h00)
         else $error("zero set on nonzero low byte");
      // R6
      logic_carry_chk: assert (op_kind[1] == 1'b0 || flags_next[POS_C] == 1'b0)
         else $error("carry set on logic op");
      // R9
      logic_ovf_chk: assert (op_kind[1] == 1'b0 || flags_next[POS_O] == 1'b0)
         else $error("overflow set on logic op");
      // R7
      aux_hold_chk: assert (op_kind[1] == 1'b0 || flags_next[POS_A] == flags_prev[POS_A])
         else $error("aux changed on logic op");
   end
endmodule

bind status_flag_builder status_flag_checker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_status_flag_builder.sv
`timescale 1ns/1ps
module test_status_flag_builder;
   logic        clk = 1'b0;
   logic [15:0] opnd_a, opnd_b, result, flags_prev;
   logic        carry_msb, carry_nib, word_op;
   logic [1:0]  op_kind;
   logic [15:0] flags_next;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   status_flag_builder i_status_flag_builder (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
      .carry_msb(carry_msb), .carry_nib(carry_nib), .op_kind(op_kind),
      .word_op(word_op), .flags_prev(flags_prev), .flags_next(flags_next)
   );

   task automatic apply(input logic [1:0] k, input logic w, input logic [15:0] a,
                        input logic [15:0] b, input logic [15:0] r, input logic cm,
                        input logic cn, input logic [15:0] fp);
      @(negedge clk);
      op_kind = k; word_op = w; opnd_a = a; opnd_b = b; result = r;
      carry_msb = cm; carry_nib = cn; flags_prev = fp;
      #1;
   endtask

   task automatic check(input string req, input logic [15:0] exp);
      n_checks++;
      if (flags_next !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%04h expected=%04h", req, flags_next, exp);
      end
   endtask

   // R1 R4 R5: all-zero inputs
   task automatic t_idle();
      apply(2'b00, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 16'h0000);
      check("R1 idle word", 16'h0046);
   endtask

   // R8 R3: byte add overflow with control flags carried
   task automatic t_add_byte_ovf();
      apply(2'b00, 1'b0, 16'h007F, 16'h0001, 16'h0080, 1'b0, 1'b1, 16'h0700);
      check("R8 byte add overflow", 16'h0F92);
   endtask

   // R6 R4: word add wrapping to zero
   task automatic t_add_word_wrap();
      apply(2'b00, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1, 16'h0000);
      check("R6 word add wrap", 16'h0057);
   endtask

   // R4: byte mode ignores upper result bits
   task automatic t_byte_zero_masked();
      apply(2'b00, 1'b0, 16'h00FF, 16'h0001, 16'h0100, 1'b1, 1'b1, 16'h0000);
      check("R4 byte zero ignores high byte", 16'h0057);
   endtask

   // R8: positive + positive overflow, word width
   task automatic t_add_word_ovf();
      apply(2'b00, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1, 16'h0000);
      check("R8 word add overflow", 16'h0896);
   endtask

   // R8 R5: negative + negative, no overflow, odd parity
   task automatic t_add_neg();
      apply(2'b00, 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b1, 1'b1, 16'h0000);
      check("R8 neg add no overflow", 16'h0093);
   endtask

   // R9: word subtract overflow
   task automatic t_sub_word_ovf();
      apply(2'b01, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 1'b1, 16'h0000);
      check("R9 word sub overflow", 16'h0816);
   endtask

   // R9 R6 R10: byte subtract borrow, no overflow
   task automatic t_sub_byte_borrow();
      apply(2'b01, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 1'b1, 1'b1, 16'h0000);
      check("R9 byte sub borrow", 16'h0097);
   endtask

   // R6 R7 R9 R10: logic class 2'b10 keeps A, clears C and O
   task automatic t_logic();
      apply(2'b10, 1'b1, 16'hF0F0, 16'h0F0F, 16'h0000, 1'b1, 1'b1, 16'h0811);
      check("R7 logic keeps aux set", 16'h0056);
      apply(2'b11, 1'b1, 16'hF0F0, 16'h0F0F, 16'h0000, 1'b1, 1'b1, 16'h0801);
      check("R10 logic class 11 aux clear", 16'h0046);
   endtask

   // R1 R2: reserved bits fixed even with all-ones previous flags
   task automatic t_reserved();
      apply(2'b00, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 16'hFFFF);
      check("R1 R2 reserved fixed control kept", 16'h0746);
      apply(2'b00, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 16'h0500);
      check("R2 partial control", 16'h0546);
   endtask

   // R5 R3: parity from low byte only in word mode
   task automatic t_parity_low();
      apply(2'b00, 1'b1, 16'h0100, 16'h0003, 16'h0103, 1'b0, 1'b0, 16'h0000);
      check("R5 parity low byte", 16'h0006);
      apply(2'b00, 1'b0, 16'h0000, 16'h0000, 16'h8001, 1'b0, 1'b0, 16'h0000);
      check("R3 byte sign ignores bit15", 16'h0002);
   endtask

   initial begin
      opnd_a = '0; opnd_b = '0; result = '0; flags_prev = '0;
      carry_msb = 1'b0; carry_nib = 1'b0; word_op = 1'b0; op_kind = 2'b00;
      t_idle();
      t_add_byte_ovf();
      t_add_word_wrap();
      t_byte_zero_masked();
      t_add_word_ovf();
      t_add_neg();
      t_sub_word_ovf();
      t_sub_byte_borrow();
      t_logic();
      t_reserved();
      t_parity_low();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule